// File: doc/BRIEF.md
# Big-Endian Byte-Addressable Bus Adapter

This block connects a processor-side request port to a memory with a 16-bit data path. Each request carries a 32-bit byte address, a two-bit size code, a write flag and 32 bits of write data. The adapter forwards only the low external address bits to the memory bus. It selects the byte lanes in big-endian order and drives an upper and a lower byte strobe. A long-word request becomes two back-to-back word cycles. Each memory cycle is held until the memory answers with a ready.

Word and long-word requests that start at an odd address are rejected. So is the reserved size code. A rejected request never reaches the memory and produces a one-cycle error pulse instead of completion. The adapter takes a new request only while idle. Completion is a one-cycle pulse that comes after the last word has been transferred. Read results stay on the result port until the next read completes.

Size codes: 2'b00 byte, 2'b01 word (16 bits), 2'b10 long word (32 bits), 2'b11 reserved.

Top module: `be_bus_adapter`

## Requirements
- R1: During reset and after reset is released, req_ready is 1 and mem_valid, done, align_err and rdata are all 0.
- R2: The first memory cycle of an accepted request puts address bits [ADDR_OUT_W-1:1] of req_addr on mem_addr, with mem_addr[0] = 0. Higher request address bits have no effect.
- R3: A request with size 2'b11, or with size word or long and req_addr[0] = 1, produces align_err = 1 for exactly the one cycle after acceptance. It produces no done, no mem_valid and no memory write.
- R4: A byte access at an even address asserts only mem_ub and carries the write byte (req_wdata[7:0]) on mem_wdata[15:8]. At an odd address it asserts only mem_lb and carries the byte on mem_wdata[7:0].
- R5: A byte read returns the selected lane (mem_rdata[15:8] for even, [7:0] for odd) in rdata[7:0], with rdata[31:8] = 0.
- R6: A word access asserts both strobes and writes req_wdata[15:0], with bits [15:8] at the even address. A word read returns {16'h0, mem_rdata}.
- R7: A long-word access makes exactly two memory cycles. The first is at address A carrying req_wdata[31:16]. The second is at A+2 (modulo 2^ADDR_OUT_W) carrying req_wdata[15:0]. A long read returns the first word in rdata[31:16] and the second in rdata[15:0].
- R8: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr, mem_wdata and the strobes keep their values on the next cycle.
- R9: done is 1 for exactly one cycle, the cycle after the final memory handshake. rdata does not change until the next read completes.
- R10: req_ready is 1 only while idle. A req_valid asserted while busy is ignored and causes no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request taken this cycle if valid |
| req_addr | input | ADDR_IN_W | Byte address |
| req_size | input | 2 | Size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle rejection pulse |
| rdata | output | 32 | Read result |
| mem_valid | output | 1 | Memory cycle requested |
| mem_ready | input | 1 | Memory cycle finished this clock |
| mem_addr | output | ADDR_OUT_W | Even byte address of the word |
| mem_we | output | 1 | Memory write |
| mem_ub | output | 1 | Strobe for bits 15..8 (even byte) |
| mem_lb | output | 1 | Strobe for bits 7..0 (odd byte) |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The bench builds the adapter with a 32-bit request address and an 8-bit external address. That makes every byte address in the external space reachable in one sweep. Each address is tried with all four size codes, both as a read and as a write, and a nonzero pattern in the upper request bits shows that those bits are dropped. The narrow space also reaches the top word, where the second half of a long word wraps to address 0. A byte-array memory model in the bench inserts zero to two wait cycles per transfer, so the hold rule is exercised.

// File: rtl/be_bus_pkg.sv
package be_bus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_XFER  = 2'b01,
    ST_DONE  = 2'b10,
    ST_FAULT = 2'b11
  } ctl_state_e;
endpackage

// File: rtl/be_rst_sync.sv
module be_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/be_ctl_fsm.sv
module be_ctl_fsm
  import be_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  xfer_size_e req_size,
  input  logic       req_lsb,
  input  logic       lat_long,
  input  logic       mem_ready,
  output ctl_state_e state_q,
  output logic       phase_q,
  output logic       accept,
  output logic       handshake
);
  ctl_state_e state_d;
  logic       phase_d;
  logic       phase_en;
  logic       misalign;

  always_comb begin
    misalign  = (req_size == SZ_RSVD) || ((req_size != SZ_BYTE) && req_lsb);
    accept    = req_valid && (state_q == ST_IDLE);
    handshake = (state_q == ST_XFER) && mem_ready;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) state_d = misalign ? ST_FAULT : ST_XFER;
      end
      ST_XFER: begin
        if (handshake && !(lat_long && !phase_q)) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    phase_en = accept || handshake;
    phase_d  = accept ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end

  assert_fault_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misalign) |=> (state_q == ST_FAULT));

  assert_fault_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT) |=> (state_q == ST_IDLE));

  assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  assert_long_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && lat_long && !phase_q) |=> (state_q == ST_XFER && phase_q));
endmodule

// File: rtl/be_req_latch.sv
module be_req_latch
  import be_bus_pkg::*;
#(
  parameter int ADDR_IN_W  = 32,
  parameter int ADDR_OUT_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_IN_W-1:0]  req_addr,
  input  xfer_size_e            req_size,
  input  logic                  req_write,
  input  logic [31:0]           req_wdata,
  input  logic                  phase,
  output logic [ADDR_OUT_W-1:0] word_addr,
  output xfer_size_e            lat_size,
  output logic                  lat_write,
  output logic                  lat_odd,
  output logic [31:0]           lat_wdata
);
  localparam int STEP_PAD = ADDR_OUT_W - 2;

  logic [ADDR_OUT_W-1:0] base_q;
  logic [ADDR_OUT_W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      lat_size  <= SZ_BYTE;
      lat_write <= 1'b0;
      lat_odd   <= 1'b0;
      lat_wdata <= '0;
    end else if (load) begin
      base_q    <= {req_addr[ADDR_OUT_W-1:1], 1'b0};
      lat_size  <= req_size;
      lat_write <= req_write;
      lat_odd   <= req_addr[0];
      lat_wdata <= req_wdata;
    end
  end

  always_comb begin
    step      = {{STEP_PAD{1'b0}}, phase, 1'b0};
    word_addr = base_q + step;
  end
endmodule

// File: rtl/be_lane_steer.sv
module be_lane_steer
  import be_bus_pkg::*;
(
  input  xfer_size_e  size,
  input  logic        odd,
  input  logic        phase,
  input  logic [31:0] wdata,
  output logic        ub,
  output logic        lb,
  output logic [15:0] lane_wdata
);
  always_comb begin
    ub         = 1'b0;
    lb         = 1'b0;
    lane_wdata = '0;
    case (size)
      SZ_BYTE: begin
        ub         = !odd;
        lb         = odd;
        lane_wdata = odd ? {8'h00, wdata[7:0]} : {wdata[7:0], 8'h00};
      end
      SZ_WORD: begin
        ub         = 1'b1;
        lb         = 1'b1;
        lane_wdata = wdata[15:0];
      end
      SZ_LONG: begin
        ub         = 1'b1;
        lb         = 1'b1;
        lane_wdata = phase ? wdata[15:0] : wdata[31:16];
      end
      default: begin
        ub         = 1'b0;
        lb         = 1'b0;
        lane_wdata = '0;
      end
    endcase
  end
endmodule

// File: rtl/be_read_pack.sv
module be_read_pack
  import be_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  xfer_size_e  size,
  input  logic        odd,
  input  logic        phase,
  input  logic [15:0] mem_rdata,
  output logic [31:0] rdata_q
);
  logic [31:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    case (size)
      SZ_BYTE: rdata_d = {24'h0, odd ? mem_rdata[7:0] : mem_rdata[15:8]};
      SZ_WORD: rdata_d = {16'h0, mem_rdata};
      SZ_LONG: rdata_d = phase ? {rdata_q[31:16], mem_rdata} : {mem_rdata, 16'h0};
      default: rdata_d = rdata_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rdata_d;
  end

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && size == SZ_BYTE) |=> (rdata_q[31:8] == 24'h0));
endmodule

// File: rtl/be_bus_adapter.sv
module be_bus_adapter
  import be_bus_pkg::*;
#(
  parameter int ADDR_IN_W  = 32,
  parameter int ADDR_OUT_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_IN_W-1:0]  req_addr,
  input  logic [1:0]            req_size,
  input  logic                  req_write,
  input  logic [31:0]           req_wdata,
  output logic                  done,
  output logic                  align_err,
  output logic [31:0]           rdata,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [ADDR_OUT_W-1:0] mem_addr,
  output logic                  mem_we,
  output logic                  mem_ub,
  output logic                  mem_lb,
  output logic [15:0]           mem_wdata,
  input  logic [15:0]           mem_rdata
);
  logic       rst_sync_n;
  ctl_state_e state_q;
  logic       phase_q;
  logic       accept;
  logic       handshake;
  xfer_size_e size_in;
  xfer_size_e lat_size;
  logic       lat_write;
  logic       lat_odd;
  logic [31:0] lat_wdata;
  logic       lat_long;
  logic       strobe_ub;
  logic       strobe_lb;

  assign size_in  = xfer_size_e'(req_size);
  assign lat_long = (lat_size == SZ_LONG);

  be_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  be_ctl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_size  (size_in),
    .req_lsb   (req_addr[0]),
    .lat_long  (lat_long),
    .mem_ready (mem_ready),
    .state_q   (state_q),
    .phase_q   (phase_q),
    .accept    (accept),
    .handshake (handshake)
  );

  be_req_latch #(
    .ADDR_IN_W  (ADDR_IN_W),
    .ADDR_OUT_W (ADDR_OUT_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (accept),
    .req_addr  (req_addr),
    .req_size  (size_in),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .phase     (phase_q),
    .word_addr (mem_addr),
    .lat_size  (lat_size),
    .lat_write (lat_write),
    .lat_odd   (lat_odd),
    .lat_wdata (lat_wdata)
  );

  be_lane_steer u_steer (
    .size       (lat_size),
    .odd        (lat_odd),
    .phase      (phase_q),
    .wdata      (lat_wdata),
    .ub         (strobe_ub),
    .lb         (strobe_lb),
    .lane_wdata (mem_wdata)
  );

  be_read_pack u_rpack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .capture   (handshake && !lat_write),
    .size      (lat_size),
    .odd       (lat_odd),
    .phase     (phase_q),
    .mem_rdata (mem_rdata),
    .rdata_q   (rdata)
  );

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    mem_valid = (state_q == ST_XFER);
    done      = (state_q == ST_DONE);
    align_err = (state_q == ST_FAULT);
    mem_we    = mem_valid && lat_write;
    mem_ub    = mem_valid && strobe_ub;
    mem_lb    = mem_valid && strobe_lb;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)
                                   && $stable(mem_ub) && $stable(mem_lb)));

  assert_strobe_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_valid && lat_size == SZ_BYTE) |-> $onehot({mem_ub, mem_lb}));

  assert_word_strobes_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_valid && lat_size != SZ_BYTE) |-> (mem_ub && mem_lb));

  assert_long_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_valid && mem_ready && lat_long && !phase_q) |=>
      (mem_addr == $past(mem_addr) + ADDR_OUT_W'(2)));

  assert_even_bus_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_valid |-> (mem_addr[0] == 1'b0));

  assert_pulses_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({done, align_err, mem_valid, req_ready}));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_ready) |=> !align_err);
endmodule

// File: tb/sim_be_bus_adapter.sv
`timescale 1ns/1ps
module sim_be_bus_adapter;
  localparam int AWI = 32;
  localparam int AWO = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [AWI-1:0]  req_addr;
  logic [1:0]      req_size;
  logic            req_write;
  logic [31:0]     req_wdata;
  logic            done;
  logic            align_err;
  logic [31:0]     rdata;
  logic            mem_valid;
  logic            mem_ready;
  logic [AWO-1:0]  mem_addr;
  logic            mem_we;
  logic            mem_ub;
  logic            mem_lb;
  logic [15:0]     mem_wdata;
  logic [15:0]     mem_rdata;

  be_bus_adapter #(.ADDR_IN_W(AWI), .ADDR_OUT_W(AWO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .done(done), .align_err(align_err), .rdata(rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_ub(mem_ub), .mem_lb(mem_lb),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] bmem  [256];
  logic [7:0] model [256];
  int         wait_cnt = 0;
  int         hs_total = 0;
  int         hold_viol = 0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_addr = 8'h0;
  logic [7:0] log_addr [4];
  logic [1:0] log_strb [4];
  int         checks = 0;
  int         failures = 0;

  assign mem_ready = mem_valid && (wait_cnt == (hs_total % 3));
  assign mem_rdata = {bmem[mem_addr], bmem[mem_addr | 8'h01]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 8'(i * 7 + 3);
    end else if (mem_valid && mem_ready && mem_we) begin
      if (mem_ub) bmem[mem_addr] <= mem_wdata[15:8];
      if (mem_lb) bmem[mem_addr | 8'h01] <= mem_wdata[7:0];
    end
    if (!mem_valid || mem_ready) wait_cnt <= 0;
    else                         wait_cnt <= wait_cnt + 1;
    if (mem_valid && mem_ready) begin
      log_addr[hs_total % 4] <= mem_addr;
      log_strb[hs_total % 4] <= {mem_ub, mem_lb};
      hs_total <= hs_total + 1;
    end
    if (prev_stall && (!mem_valid || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
    prev_stall <= mem_valid && !mem_ready;
    prev_addr  <= mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 256; i++) if (bmem[i] !== model[i]) n++;
    return n;
  endfunction

  task automatic run_req(input logic [7:0] a, input logic [1:0] sz, input logic we,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output logic err, output int nhs, output int base);
    logic seen;
    @(negedge clk);
    chk("R10 ready when idle", {31'h0, req_ready}, 32'h1);
    base      = hs_total;
    req_valid = 1'b1;
    req_addr  = {24'hC3A55A, a};
    req_size  = sz;
    req_write = we;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int t = 0; t < 40 && !seen; t++) begin
      if (done || align_err) seen = 1'b1;
      else @(negedge clk);
    end
    err = align_err;
    rd  = rdata;
    nhs = hs_total - base;
    @(negedge clk);
    chk("R9 pulse one cycle", {30'h0, done, align_err}, 32'h0);
    chk("R9 rdata held", rdata, rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        err;
    logic        bad;
    logic [7:0]  b;
    int          nhs;
    int          base;
    int          seen;

    for (int i = 0; i < 256; i++) model[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = 2'b00;
    req_write = 1'b0; req_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 in reset", {req_ready, mem_valid, done, align_err}, 32'h8);
    chk("R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {req_ready, mem_valid, done, align_err}, 32'h8);
    chk("R1 rdata after reset", rdata, 32'h0);

    // R10: a request held while busy must be ignored
    base = hs_total;
    req_valid = 1'b1; req_addr = {24'h123456, 8'h40}; req_size = 2'b10;
    req_write = 1'b1; req_wdata = 32'h11223344;
    @(negedge clk);
    req_addr = {24'h0, 8'h81}; req_size = 2'b00; req_wdata = 32'h000000EE;
    chk("R10 not ready when busy", {31'h0, req_ready}, 32'h0);
    seen = 0;
    for (int t = 0; t < 40 && seen == 0; t++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    req_valid = 1'b0;
    model[8'h40] = 8'h11; model[8'h41] = 8'h22; model[8'h42] = 8'h33; model[8'h43] = 8'h44;
    @(negedge clk);
    chk("R10 busy request ignored, transfers", 32'(hs_total - base), 32'd2);
    chk("R10 busy request ignored, memory", 32'(mem_diff()), 32'd0);

    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int we = 0; we < 2; we++) begin
          wd  = {8'(a) ^ 8'hA5, 8'(a + 17), ~8'(a), 8'(a * 3 + sz)};
          bad = (sz == 3) || (sz != 0 && a[0]);
          b   = 8'(a) & 8'hFE;
          run_req(8'(a), 2'(sz), we[0], wd, rd, err, nhs, base);
          chk("R3 error flag", {31'h0, err}, {31'h0, bad});
          if (bad) begin
            chk("R3 no memory cycle", 32'(nhs), 32'd0);
            chk("R3 memory untouched", 32'(mem_diff()), 32'd0);
          end else begin
            chk("R7 transfer count", 32'(nhs), (sz == 2) ? 32'd2 : 32'd1);
            chk("R2 first address", {24'h0, log_addr[base % 4]}, {24'h0, b});
            if (sz == 0)
              chk("R4 byte strobe", {30'h0, log_strb[base % 4]}, a[0] ? 32'h1 : 32'h2);
            else
              chk("R6 word strobes", {30'h0, log_strb[base % 4]}, 32'h3);
            if (sz == 2)
              chk("R7 second address", {24'h0, log_addr[(base + 1) % 4]}, {24'h0, 8'(b + 2)});
            if (we == 1) begin
              if (sz == 0) model[8'(a)] = wd[7:0];
              else if (sz == 1) begin
                model[b] = wd[15:8]; model[8'(b + 1)] = wd[7:0];
              end else begin
                model[b] = wd[31:24]; model[8'(b + 1)] = wd[23:16];
                model[8'(b + 2)] = wd[15:8]; model[8'(b + 3)] = wd[7:0];
              end
              chk((sz == 0) ? "R4 byte write" : (sz == 1) ? "R6 word write" : "R7 long write",
                  32'(mem_diff()), 32'd0);
            end else begin
              if (sz == 0) exp_rd = {24'h0, model[8'(a)]};
              else if (sz == 1) exp_rd = {16'h0, model[b], model[8'(b + 1)]};
              else exp_rd = {model[b], model[8'(b + 1)], model[8'(b + 2)], model[8'(b + 3)]};
              chk((sz == 0) ? "R5 byte read" : (sz == 1) ? "R6 word read" : "R7 long read",
                  rd, exp_rd);
            end
          end
        end
      end
    end

    chk("R8 bus held while stalled", 32'(hold_viol), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule